// File: doc/BRIEF.md
# DSP Autoboot Supervisor

This block sits on the host side of a board and brings an external signal processor up from paged external memory. It holds the processor in reset with the first-code page selected. It then pulls the shared boot/interrupt pin low and releases reset. After one more cycle it lets go of that pin. It then waits a fixed download window, during which anything the processor drives on that pin is kept away from the host.

When the window ends, the supervisor reads one known application variable through a single-request read port and compares the value with a configured default. A mismatch or a read timeout leads to one delayed second read. If that second read also fails, the whole boot starts again from reset. After a set number of full attempts, the block stops in a failed state. A matching read ends in a ready state that passes the processor's interrupt through to the host.

The expected value must not be all zeros or all ones. Such a value is rejected when the design is elaborated.

States, in boot order:
- `ST_HOLD`: the processor is held in reset with the boot pin pulled.
- `ST_LET_GO`: reset is released while the pin is still pulled.
- `ST_LOAD_WAIT`: the download window.
- `ST_READ_A`: the first read.
- `ST_PAUSE`: the retry delay.
- `ST_READ_B`: the second read.
- `ST_READY`: the boot succeeded.
- `ST_HALT`: all attempts failed.

Transitions:
- HOLD to LET_GO after `RST_CYC` cycles.
- LET_GO to LOAD_WAIT after one cycle.
- LOAD_WAIT to READ_A after `DL_CYC` cycles.
- READ_A to READY on a match, or to PAUSE on a mismatch or timeout.
- PAUSE to READ_B after `RETRY_CYC` cycles.
- READ_B to READY on a match.
- READ_B on a mismatch or timeout goes to HOLD, or to HALT when the attempt was the last allowed one.

Top module: `dsp_boot_supervisor`

## Requirements
- R1: `page_sel` always equals `BOOT_PAGE` with its bit 0 forced to 0, so the lowest page line is low while the processor is in reset.
- R2: `dsp_rst_n` is low while `rst_n` is low. In each boot attempt it is low for exactly `RST_CYC` cycles after the host reset is released or after the attempt begins.
- R3: `bootreq_pull` (1 = drive pin low, 0 = release) is 1 for every cycle in which `dsp_rst_n` is 0, except in the failed state. After `dsp_rst_n` rises it stays 1 for exactly one cycle and then goes to 0.
- R4: `rd_req` rises exactly `DL_CYC` cycles after `bootreq_pull` falls, counting the cycle of the fall as the first. `rd_addr` equals `VAR_ADDR` whenever `rd_req` is 1.
- R5: `irq_n_out` is 1 whenever `boot_done` is 0. In the ready state it equals `bootreq_pin`.
- R6: `rd_req` stays 1 up to and including the cycle in which `rd_valid` is seen. If `rd_data` equals `EXP_VAL` in that cycle, `rd_req` drops and `boot_done` rises on the next cycle.
- R7: A read with no `rd_valid` ends after `RD_TIMEOUT` cycles of `rd_req` and counts as a mismatch.
- R8: After a failed first read, `rd_req` stays 0 for exactly `RETRY_CYC` cycles before the second request.
- R9: If the second read fails and attempts remain, `dsp_rst_n` falls in the cycle after that read and the full boot sequence repeats.
- R10: `boot_done` is sticky. Once it is set, no further read or reset of the processor happens.
- R11: When `MAX_BOOTS` attempts have all failed, `boot_fail` goes to 1 and stays there. The processor is held in reset, the pin is released, and no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release host reset |
| dsp_rst_n | output | 1 | Active-low reset to the processor |
| bootreq_pull | output | 1 | Open-drain enable: 1 pulls the shared boot pin low |
| bootreq_pin | input | 1 | Level sensed on the shared boot/interrupt pin |
| page_sel | output | PAGE_W | Memory page-select lines |
| rd_req | output | 1 | Read request to the processor host port |
| rd_addr | output | ADDR_W | Address of the checked variable |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read response data |
| irq_n_out | output | 1 | Active-low interrupt to the host, masked until boot is done |
| boot_done | output | 1 | Boot verified |
| boot_fail | output | 1 | All boot attempts failed |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| `RST_CYC` | 3 |
| `DL_CYC` | 20 |
| `RETRY_CYC` | 7 |
| `RD_TIMEOUT` | 5 |
| `MAX_BOOTS` | 2 |
| `BOOT_PAGE` | 3'b111 |

A 3-bit page value of all ones shows that the lowest line is forced low. The short delays let every path be measured to the exact cycle in a few hundred clocks: a first-read match, a retry that matches, a timeout followed by a reboot, and the exhaustion of both attempts. Two attempts are enough to reach both the reboot path and the failed state.

// File: rtl/dsp_boot_pkg.sv
package dsp_boot_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LET_GO,
        ST_LOAD_WAIT,
        ST_READ_A,
        ST_PAUSE,
        ST_READ_B,
        ST_READY,
        ST_HALT
    } boot_state_e;

endpackage

// File: rtl/bsup_cycle_timer.sv
module bsup_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end

    // Saturating counter never wraps back to zero without a clear.
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == TOP && !$past(clear)) |-> count == TOP); // R2
endmodule

// File: rtl/bsup_value_match.sv
module bsup_value_match #(
    parameter int                 DATA_W  = 16,
    parameter logic [DATA_W-1:0]  EXP_VAL = 16'h5AA5
) (
    input  logic [DATA_W-1:0] data,
    output logic              hit
);
    generate
        if (EXP_VAL == '0 || EXP_VAL == {DATA_W{1'b1}}) begin : g_weak_exp
            $error("EXP_VAL must not be all zeros or all ones");
        end
    endgenerate

    assign hit = (data == EXP_VAL);
endmodule

// File: rtl/dsp_boot_supervisor.sv
module dsp_boot_supervisor
    import dsp_boot_pkg::*;
#(
    parameter int                 RST_CYC    = 16,
    parameter int                 DL_CYC     = 17_500_000,
    parameter int                 RETRY_CYC  = 500_000,
    parameter int                 RD_TIMEOUT = 1024,
    parameter int                 MAX_BOOTS  = 3,
    parameter int                 PAGE_W     = 3,
    parameter logic [PAGE_W-1:0]  BOOT_PAGE  = '0,
    parameter int                 ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]  VAR_ADDR   = 16'h0040,
    parameter int                 DATA_W     = 16,
    parameter logic [DATA_W-1:0]  EXP_VAL    = 16'h5AA5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              dsp_rst_n,
    output logic              bootreq_pull,
    input  logic              bootreq_pin,
    output logic [PAGE_W-1:0] page_sel,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              irq_n_out,
    output logic              boot_done,
    output logic              boot_fail
);
    localparam int CW = $clog2(RST_CYC + DL_CYC + RETRY_CYC + RD_TIMEOUT + 1);
    localparam int BW = $clog2(MAX_BOOTS + 1);
    localparam logic [CW-1:0] T_RST   = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] T_DL    = CW'(DL_CYC - 1);
    localparam logic [CW-1:0] T_RETRY = CW'(RETRY_CYC - 1);
    localparam logic [CW-1:0] T_RD    = CW'(RD_TIMEOUT - 1);
    localparam logic [BW-1:0] LAST_BOOT = BW'(MAX_BOOTS - 1);

    boot_state_e     state_q, state_n;
    logic [CW-1:0]   tcount;
    logic [BW-1:0]   boots_q;
    logic            hit;
    logic            rd_fail;

    bsup_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_n != state_q),
        .count (tcount)
    );

    bsup_value_match #(.DATA_W(DATA_W), .EXP_VAL(EXP_VAL)) u_match (
        .data (rd_data),
        .hit  (hit)
    );

    // A read fails on a wrong value or when its window runs out.
    assign rd_fail = rd_valid ? !hit : (tcount == T_RD);

    // State register and attempt counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            boots_q <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_READ_B && state_n == ST_HOLD) begin
                boots_q <= boots_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD:      if (tcount == T_RST) state_n = ST_LET_GO;
            ST_LET_GO:    state_n = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (tcount == T_DL) state_n = ST_READ_A;
            ST_READ_A: begin
                if (rd_valid && hit) state_n = ST_READY;
                else if (rd_fail)    state_n = ST_PAUSE;
            end
            ST_PAUSE:     if (tcount == T_RETRY) state_n = ST_READ_B;
            ST_READ_B: begin
                if (rd_valid && hit)         state_n = ST_READY;
                else if (rd_fail)            state_n = (boots_q == LAST_BOOT) ? ST_HALT : ST_HOLD;
            end
            ST_READY:     state_n = ST_READY;
            ST_HALT:      state_n = ST_HALT;
            default:      state_n = ST_HOLD;
        endcase
    end

    // Moore outputs
    always_comb begin
        dsp_rst_n    = 1'b1;
        bootreq_pull = 1'b0;
        rd_req       = 1'b0;
        irq_n_out    = 1'b1;
        boot_done    = 1'b0;
        boot_fail    = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                dsp_rst_n    = 1'b0;
                bootreq_pull = 1'b1;
            end
            ST_LET_GO:    bootreq_pull = 1'b1;
            ST_LOAD_WAIT: ;
            ST_READ_A:    rd_req = 1'b1;
            ST_PAUSE:     ;
            ST_READ_B:    rd_req = 1'b1;
            ST_READY: begin
                boot_done = 1'b1;
                irq_n_out = bootreq_pin;
            end
            ST_HALT: begin
                dsp_rst_n = 1'b0;
                boot_fail = 1'b1;
            end
            default: ;
        endcase
    end

    assign page_sel = {BOOT_PAGE[PAGE_W-1:1], 1'b0};
    assign rd_addr  = VAR_ADDR;

    AST_PULL_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsp_rst_n) |-> bootreq_pull); // R3
    AST_PULL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bootreq_pull) |-> (dsp_rst_n && $past(dsp_rst_n))); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> irq_n_out); // R5
    AST_REQ_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (dsp_rst_n && !bootreq_pull)); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (boot_done && !rd_req && dsp_rst_n)); // R10
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fail |=> (boot_fail && !rd_req && !dsp_rst_n)); // R11
endmodule

// File: tb/dsp_boot_supervisor_tb.sv
module dsp_boot_supervisor_tb_top;
    localparam int RC = 3, DL = 20, RT = 7, TO = 5, MB = 2;
    localparam logic [2:0]  BPAGE = 3'b111;
    localparam logic [2:0]  EXP_PAGE = 3'b110;
    localparam logic [15:0] VADDR = 16'h01C4;
    localparam logic [15:0] EXPV  = 16'hA55A;
    localparam int EV_REL = 1, EV_READ = 2, EV_RDEND = 3, EV_DONE = 4, EV_FAIL = 5;
    localparam int R_GOOD = 0, R_BAD = 1, R_NONE = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic dsp_rst_n, bootreq_pull, bootreq_pin, rd_req, rd_valid = 1'b0;
    logic irq_n_out, boot_done, boot_fail;
    logic [2:0]  page_sel;
    logic [15:0] rd_addr, rd_data = '0;
    logic dsp_irq_n_drv = 1'b1;
    bit   tog_en = 1'b1;

    assign bootreq_pin = bootreq_pull ? 1'b0 : dsp_irq_n_drv;

    dsp_boot_supervisor #(
        .RST_CYC(RC), .DL_CYC(DL), .RETRY_CYC(RT), .RD_TIMEOUT(TO), .MAX_BOOTS(MB),
        .PAGE_W(3), .BOOT_PAGE(BPAGE), .ADDR_W(16), .VAR_ADDR(VADDR),
        .DATA_W(16), .EXP_VAL(EXPV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .dsp_rst_n(dsp_rst_n), .bootreq_pull(bootreq_pull),
        .bootreq_pin(bootreq_pin), .page_sel(page_sel), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_n_out(irq_n_out),
        .boot_done(boot_done), .boot_fail(boot_fail)
    );

    typedef struct { int kind; int val; string tag; } ev_t;
    ev_t expq[$];
    int  rkind[$];
    int  rdly[$];

    int checks = 0, fails = 0;
    int page_err, pull_err, mask_err;
    bit finished = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_ev(int k, int v, string tag);
        ev_t e;
        e.kind = k; e.val = v; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic observe(int k, int v);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R10", "unexpected event kind*1000+value", k * 1000 + v, 0);
        end else begin
            e = expq.pop_front();
            chk(k == e.kind && v == e.val, e.tag, "event kind*1000+value",
                k * 1000 + v, e.kind * 1000 + e.val);
        end
    endtask

    // Monitor: turns port activity into timed events and pops the scoreboard.
    logic p_rst, p_pull, p_req, p_done, p_fail;
    int lowcnt, since, postpull, reqlen;
    always @(negedge clk) begin
        if (!rst_n) begin
            p_rst = dsp_rst_n; p_pull = bootreq_pull; p_req = rd_req;
            p_done = boot_done; p_fail = boot_fail;
            lowcnt = 0; since = 0; postpull = 0; reqlen = 0;
        end else begin
            if (!dsp_rst_n) begin
                lowcnt++;
                if (!boot_fail && !bootreq_pull) pull_err++;
            end
            if (page_sel != EXP_PAGE) page_err++;
            if (!boot_done && !irq_n_out) mask_err++;
            if (dsp_rst_n && !p_rst) begin
                observe(EV_REL, lowcnt);
                lowcnt = 0;
                postpull = 0;
            end
            if (dsp_rst_n && bootreq_pull) postpull++;
            if (p_pull && !bootreq_pull && dsp_rst_n) begin
                chk(postpull == 1, "R3", "pull cycles after reset release", postpull, 1);
                since = 1;
            end else if (rd_req && !p_req) begin
                observe(EV_READ, since);
                chk(rd_addr == VADDR, "R4", "read address", rd_addr, VADDR);
                reqlen = 1;
            end else if (rd_req) begin
                reqlen++;
            end else if (p_req) begin
                observe(EV_RDEND, reqlen);
                since = 1;
            end else begin
                since++;
            end
            if (boot_done && !p_done) observe(EV_DONE, 0);
            if (boot_fail && !p_fail) observe(EV_FAIL, 0);
            p_rst = dsp_rst_n; p_pull = bootreq_pull; p_req = rd_req;
            p_done = boot_done; p_fail = boot_fail;
        end
    end

    // Responder: answers each new request from the response queue.
    initial begin
        logic prev = 1'b0;
        int k, d;
        forever begin
            @(negedge clk);
            if (rst_n && rd_req && !prev && rkind.size() > 0) begin
                k = rkind.pop_front();
                d = rdly.pop_front();
                if (k != R_NONE) begin
                    repeat (d + 1) @(posedge clk);
                    #1;
                    rd_valid = 1'b1;
                    rd_data  = (k == R_GOOD) ? EXPV : (EXPV ^ 16'h0100);
                    @(posedge clk);
                    #1;
                    rd_valid = 1'b0;
                end
                prev = 1'b1;
            end else begin
                prev = rd_req;
            end
        end
    end

    // Processor-side interrupt activity on the shared pin.
    initial forever begin
        @(posedge clk);
        #1;
        if (tog_en) dsp_irq_n_drv = ~dsp_irq_n_drv;
    end

    task automatic push_resp(int k, int d);
        rkind.push_back(k);
        rdly.push_back(d);
    endtask

    task automatic host_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        page_err = 0; pull_err = 0; mask_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dsp_rst_n == 1'b0, "R2", "dsp_rst_n during host reset", dsp_rst_n, 0);
        chk(bootreq_pull == 1'b1 && rd_req == 1'b0, "R3", "pull/req during host reset",
            {bootreq_pull, rd_req}, 2);
        chk(boot_done == 1'b0 && boot_fail == 1'b0, "R10", "status during host reset",
            {boot_done, boot_fail}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_case();
        int n = 0;
        while (expq.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R9", "missing events", expq.size(), 0);
        repeat (20) @(negedge clk);
        chk(page_err == 0, "R1", "page_sel mismatches", page_err, 0);
        chk(pull_err == 0, "R3", "reset cycles without pull", pull_err, 0);
        chk(mask_err == 0, "R5", "interrupts leaked before done", mask_err, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired cycles", 200000, 0);
        summary();
    end

    initial begin
        // Case 1: first read matches (R6, R10, R5 pass-through)
        push_resp(R_GOOD, 1);
        expect_ev(EV_REL, RC, "R2"); expect_ev(EV_READ, DL, "R4");
        expect_ev(EV_RDEND, 3, "R6"); expect_ev(EV_DONE, 0, "R6");
        host_reset();
        finish_case();
        chk(dsp_rst_n == 1'b1 && rd_req == 1'b0 && boot_done == 1'b1, "R10",
            "ready state outputs", {dsp_rst_n, rd_req, boot_done}, 5);
        tog_en = 1'b0;
        @(posedge clk); #1 dsp_irq_n_drv = 1'b0;
        @(negedge clk);
        chk(irq_n_out == 1'b0, "R5", "irq pass-through low", irq_n_out, 0);
        @(posedge clk); #1 dsp_irq_n_drv = 1'b1;
        @(negedge clk);
        chk(irq_n_out == 1'b1, "R5", "irq pass-through high", irq_n_out, 1);
        tog_en = 1'b1;

        // Case 2: mismatch, retry matches (R8)
        push_resp(R_BAD, 0); push_resp(R_GOOD, 2);
        expect_ev(EV_REL, RC, "R2"); expect_ev(EV_READ, DL, "R4");
        expect_ev(EV_RDEND, 2, "R6"); expect_ev(EV_READ, RT, "R8");
        expect_ev(EV_RDEND, 4, "R6"); expect_ev(EV_DONE, 0, "R8");
        host_reset();
        finish_case();

        // Case 3: timeout, retry mismatch, full reboot, then match (R7, R9)
        push_resp(R_NONE, 0); push_resp(R_BAD, 1); push_resp(R_GOOD, 0);
        expect_ev(EV_REL, RC, "R2"); expect_ev(EV_READ, DL, "R4");
        expect_ev(EV_RDEND, TO, "R7"); expect_ev(EV_READ, RT, "R8");
        expect_ev(EV_RDEND, 3, "R6"); expect_ev(EV_REL, RC, "R9");
        expect_ev(EV_READ, DL, "R4"); expect_ev(EV_RDEND, 2, "R6");
        expect_ev(EV_DONE, 0, "R9");
        host_reset();
        finish_case();

        // Case 4: every attempt fails (R11)
        push_resp(R_BAD, 0); push_resp(R_NONE, 0); push_resp(R_BAD, 1); push_resp(R_BAD, 0);
        expect_ev(EV_REL, RC, "R2"); expect_ev(EV_READ, DL, "R4");
        expect_ev(EV_RDEND, 2, "R6"); expect_ev(EV_READ, RT, "R8");
        expect_ev(EV_RDEND, TO, "R7"); expect_ev(EV_REL, RC, "R9");
        expect_ev(EV_READ, DL, "R4"); expect_ev(EV_RDEND, 3, "R6");
        expect_ev(EV_READ, RT, "R8"); expect_ev(EV_RDEND, 2, "R6");
        expect_ev(EV_FAIL, 0, "R11");
        host_reset();
        finish_case();
        chk(boot_fail == 1'b1 && dsp_rst_n == 1'b0 && bootreq_pull == 1'b0 && rd_req == 1'b0,
            "R11", "failed state outputs", {boot_fail, dsp_rst_n, bootreq_pull, rd_req}, 8);

        summary();
    end
endmodule